// File: doc/BRIEF.md
# UART Modem-Line Flow Controller

This block handles automatic hardware flow control for one UART channel. It watches the receive FIFO fill level. When the level climbs to an upper threshold, it releases an active-low request line so the far end stops sending. It drives the line active again only after the level has fallen below a lower threshold, which gives the control hysteresis.

On the transmit side, the block samples an active-low clear line from the far end through a synchroniser. It then grants or withholds permission to the serial transmitter, but only at character boundaries, so a character already being shifted out always finishes.

One select bit chooses which modem pair is used: the request/clear pair (RTS with CTS) or the terminal-ready/set-ready pair (DTR with DSR). The request pin that is not selected, and the selected pin whenever automatic receive control is off, act as plain general-purpose outputs that follow their manual bits. The block also raises a receive-threshold interrupt from the FIFO level.

Top module: `uart_flow_ctl`

## Requirements
- R1: After reset, the hold-off state is clear, `txAllow` is 1, `rxIrq` is 0, and each request pin is the inverse of its manual bit.
- R2: With `autoRxEn` = 0, the selected request pin equals the inverse of its manual bit, whatever the FIFO level.
- R3: With `autoRxEn` = 1 and the selected manual bit = 1, the selected pin goes high one clock after `rxLevel` >= `upperThr` is sampled.
- R4: Once high through R3, the pin stays high while `rxLevel` >= `lowerThr`. It returns low one clock after `rxLevel` < `lowerThr` is sampled.
- R5: When `lowerThr` >= `upperThr`, a held-off pin returns low one clock after `rxLevel` < `upperThr` is sampled.
- R6: Automatic receive control acts only while the selected manual bit is 1. When that bit is 0, the pin is high, and the hold-off state is cleared on the next clock.
- R7: `lineSel` = 0 selects `rtsN` for requests and `ctsN` as the clear input. `lineSel` = 1 selects `dtrN` and `dsrN`. The pin that is not selected always equals the inverse of its own manual bit.
- R8: With `autoTxEn` = 0, `txAllow` is 1 from the next clock on.
- R9: With `autoTxEn` = 1, the selected clear input passes through a two-flop synchroniser. At each clock where `txBoundary` = 1, `txAllow` is loaded with the inverse of the synchronised value. At other clocks it holds its value.
- R10: `rxIrq` is a registered flag that is 1 one clock after `rxLevel` >= `trigLevel` is sampled, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| autoRxEn | input | 1 | Enable automatic receive flow control |
| autoTxEn | input | 1 | Enable automatic transmit flow control |
| lineSel | input | 1 | 0: RTS/CTS pair, 1: DTR/DSR pair |
| manualRts | input | 1 | Manual request bit for the RTS pin (1 = assert) |
| manualDtr | input | 1 | Manual request bit for the DTR pin (1 = assert) |
| ctsN | input | 1 | Active-low clear-to-send input, asynchronous |
| dsrN | input | 1 | Active-low set-ready input, asynchronous |
| txBoundary | input | 1 | Transmitter is between characters |
| rxLevel | input | 7 | Receive FIFO fill, 0 to 64 |
| upperThr | input | 7 | Hold-off threshold |
| lowerThr | input | 7 | Release threshold |
| trigLevel | input | 7 | Receive interrupt trigger level |
| rtsN | output | 1 | Active-low RTS pin |
| dtrN | output | 1 | Active-low DTR pin |
| txAllow | output | 1 | Transmitter may start a character |
| rxIrq | output | 1 | Receive level reached trigger |

## Verification
The hardest case to reach is the band between the two thresholds. There the pin's value depends on the direction the level came from, not on the level itself. Reaching it needs a climb past the upper threshold and then a descent that stops short of the lower one. Directed ramps cover that band, including the inverted-threshold case and a manual-bit drop while the pin is held off. A random walk on `rxLevel` then crosses the thresholds repeatedly while the thresholds, selects and boundary strobe also change.

// File: rtl/flow_ctl_pkg.sv
package flow_ctl_pkg;
  // status the datapath reports to the control
  typedef struct packed {
    logic atUpper;
    logic belowLower;
    logic clearHigh;
    logic reqManual;
  } dpStat_t;

  // state the control hands to the datapath
  typedef struct packed {
    logic holdOff;
    logic txAllow;
  } ctlStrb_t;
endpackage

// File: rtl/flow_ctl_dp.sv
module flow_ctl_dp
  import flow_ctl_pkg::*;
#(
  parameter int LVL_W       = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lineSel,
  input  logic             manualRts,
  input  logic             manualDtr,
  input  logic             ctsN,
  input  logic             dsrN,
  input  logic [LVL_W-1:0] rxLevel,
  input  logic [LVL_W-1:0] upperThr,
  input  logic [LVL_W-1:0] lowerThr,
  input  logic [LVL_W-1:0] trigLevel,
  input  ctlStrb_t         ctl,
  output dpStat_t          stat,
  output logic             rtsN,
  output logic             dtrN,
  output logic             rxIrq
);
  localparam int NUM_LINES = 2;

  logic [NUM_LINES-1:0] clearRaw;
  logic [NUM_LINES-1:0] clearSync;
  logic                 reqPinN;
  logic                 lowerValid;

  assign clearRaw = {dsrN, ctsN};

  // one synchroniser chain per clear line; reset to "not clear"
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_sync
    logic [SYNC_STAGES-1:0] stage;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stage <= '1;
      else       stage <= {stage[SYNC_STAGES-2:0], clearRaw[g]};
    end
    assign clearSync[g] = stage[SYNC_STAGES-1];
  end

  // threshold compare; inverted thresholds fall back to the upper bound
  assign lowerValid      = lowerThr < upperThr;
  assign stat.atUpper    = rxLevel >= upperThr;
  assign stat.belowLower = lowerValid ? (rxLevel < lowerThr) : (rxLevel < upperThr);
  assign stat.clearHigh  = lineSel ? clearSync[1] : clearSync[0];
  assign stat.reqManual  = lineSel ? manualDtr : manualRts;

  // pin mux: selected pin carries the automatic request, other is GPIO
  assign reqPinN = !(stat.reqManual && !ctl.holdOff);
  assign rtsN    = lineSel ? !manualRts : reqPinN;
  assign dtrN    = lineSel ? reqPinN : !manualDtr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxIrq <= 1'b0;
    else       rxIrq <= rxLevel >= trigLevel;
  end

  // R7
  unsel_rts_chk: assert property (@(posedge clk) disable iff (!rstN)
    lineSel |-> (rtsN == !manualRts));
  // R7
  unsel_dtr_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lineSel |-> (dtrN == !manualDtr));
  // R6
  manual_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!lineSel && !manualRts) |-> rtsN);
endmodule

// File: rtl/flow_ctl_ctrl.sv
module flow_ctl_ctrl
  import flow_ctl_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     autoRxEn,
  input  logic     autoTxEn,
  input  logic     txBoundary,
  input  dpStat_t  stat,
  output ctlStrb_t ctl
);
  logic holdOff;
  logic holdNext;
  logic txAllow;
  logic allowNext;

  always_comb begin
    holdNext = holdOff;
    if (!(autoRxEn && stat.reqManual))   holdNext = 1'b0;
    else if (holdOff && stat.belowLower) holdNext = 1'b0;
    else if (!holdOff && stat.atUpper)   holdNext = 1'b1;
  end

  always_comb begin
    allowNext = txAllow;
    if (!autoTxEn)       allowNext = 1'b1;
    else if (txBoundary) allowNext = !stat.clearHigh;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdOff <= 1'b0;
      txAllow <= 1'b1;
    end else begin
      holdOff <= holdNext;
      txAllow <= allowNext;
    end
  end

  assign ctl.holdOff = holdOff;
  assign ctl.txAllow = txAllow;

  // R3
  hold_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (autoRxEn && stat.reqManual && stat.atUpper && !holdOff) |=> holdOff);
  // R6
  hold_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(autoRxEn && stat.reqManual) |=> !holdOff);
  // R8
  tx_free_chk: assert property (@(posedge clk) disable iff (!rstN)
    !autoTxEn |=> txAllow);
  // R9
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (autoTxEn && !txBoundary) |=> $stable(txAllow));
endmodule

// File: rtl/uart_flow_ctl.sv
module uart_flow_ctl
  import flow_ctl_pkg::*;
#(
  parameter int FIFO_DEPTH  = 64,
  parameter int SYNC_STAGES = 2,
  localparam int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             autoRxEn,
  input  logic             autoTxEn,
  input  logic             lineSel,
  input  logic             manualRts,
  input  logic             manualDtr,
  input  logic             ctsN,
  input  logic             dsrN,
  input  logic             txBoundary,
  input  logic [LVL_W-1:0] rxLevel,
  input  logic [LVL_W-1:0] upperThr,
  input  logic [LVL_W-1:0] lowerThr,
  input  logic [LVL_W-1:0] trigLevel,
  output logic             rtsN,
  output logic             dtrN,
  output logic             txAllow,
  output logic             rxIrq
);
  dpStat_t  stat;
  ctlStrb_t ctl;

  flow_ctl_dp #(.LVL_W(LVL_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .lineSel(lineSel),
    .manualRts(manualRts), .manualDtr(manualDtr),
    .ctsN(ctsN), .dsrN(dsrN), .rxLevel(rxLevel),
    .upperThr(upperThr), .lowerThr(lowerThr), .trigLevel(trigLevel),
    .ctl(ctl), .stat(stat), .rtsN(rtsN), .dtrN(dtrN), .rxIrq(rxIrq)
  );

  flow_ctl_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .autoRxEn(autoRxEn), .autoTxEn(autoTxEn),
    .txBoundary(txBoundary), .stat(stat), .ctl(ctl)
  );

  assign txAllow = ctl.txAllow;
endmodule

// File: tb/uart_flow_ctl_tb.sv
module uart_flow_ctl_tb;
  localparam int CLK_NS = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic autoRxEn = 0, autoTxEn = 0, lineSel = 0, manualRts = 0, manualDtr = 0;
  logic ctsN = 1, dsrN = 1, txBoundary = 1;
  logic [6:0] rxLevel = 0, upperThr = 40, lowerThr = 20, trigLevel = 32;
  logic rtsN, dtrN, txAllow, rxIrq;

  int nChecks = 0, nFails = 0;
  bit done = 0;

  // bench model state
  bit mHold = 0, mAllow = 1, mIrq = 0;
  bit s1c = 1, s2c = 1, s1d = 1, s2d = 1;

  always #(CLK_NS/2) clk = ~clk;

  uart_flow_ctl u_dut (
    .clk(clk), .rstN(rstN), .autoRxEn(autoRxEn), .autoTxEn(autoTxEn),
    .lineSel(lineSel), .manualRts(manualRts), .manualDtr(manualDtr),
    .ctsN(ctsN), .dsrN(dsrN), .txBoundary(txBoundary), .rxLevel(rxLevel),
    .upperThr(upperThr), .lowerThr(lowerThr), .trigLevel(trigLevel),
    .rtsN(rtsN), .dtrN(dtrN), .txAllow(txAllow), .rxIrq(rxIrq)
  );

  function automatic bit expPin(bit sel, bit isDtr, bit man, bit hold);
    if (sel == isDtr) return !(man && !hold);
    return !man;
  endfunction

  task automatic chk(string tag, string what, bit got, bit exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s %s: got %0b expected %0b at %0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic modelEdge();
    bit reqM, clrM, atUp, belowLo;
    reqM    = lineSel ? manualDtr : manualRts;
    clrM    = lineSel ? s2d : s2c;
    atUp    = rxLevel >= upperThr;
    belowLo = (lowerThr < upperThr) ? (rxLevel < lowerThr) : (rxLevel < upperThr);
    if (!(autoRxEn && reqM))   mHold = 0;
    else if (mHold && belowLo) mHold = 0;
    else if (!mHold && atUp)   mHold = 1;
    if (!autoTxEn)       mAllow = 1;
    else if (txBoundary) mAllow = !clrM;
    mIrq = rxLevel >= trigLevel;
    s2c = s1c; s1c = ctsN;
    s2d = s1d; s1d = dsrN;
  endtask

  task automatic compareAll();
    chk("R7", "rtsN", rtsN, expPin(lineSel, 0, manualRts, mHold));
    chk("R7", "dtrN", dtrN, expPin(lineSel, 1, manualDtr, mHold));
    chk("R9", "txAllow", txAllow, mAllow);
    chk("R10", "rxIrq", rxIrq, mIrq);
  endtask

  task automatic step();
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    compareAll();
  endtask

  initial begin : watchdog
    #(CLK_NS * 200000);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1", "rtsN", rtsN, 1); chk("R1", "dtrN", dtrN, 1);
    chk("R1", "txAllow", txAllow, 1); chk("R1", "rxIrq", rxIrq, 0);
    rstN = 1;
    ctsN = 0; dsrN = 0;
    repeat (3) step();

    // R3 / R4 hysteresis on RTS
    autoRxEn = 1; manualRts = 1; upperThr = 40; lowerThr = 20;
    rxLevel = 39; step(); chk("R3", "rtsN below upper", rtsN, 0);
    rxLevel = 40; step(); chk("R3", "rtsN at upper", rtsN, 1);
    rxLevel = 25; step(); chk("R4", "rtsN in band", rtsN, 1);
    rxLevel = 20; step(); chk("R4", "rtsN at lower", rtsN, 1);
    rxLevel = 19; step(); chk("R4", "rtsN below lower", rtsN, 0);
    rxLevel = 30; step(); chk("R4", "rtsN rising band", rtsN, 0);

    // R5 inverted thresholds
    lowerThr = 50;
    rxLevel = 45; step(); chk("R5", "rtsN held", rtsN, 1);
    rxLevel = 39; step(); chk("R5", "rtsN released", rtsN, 0);
    lowerThr = 20;

    // R6 manual bit gates the automatic control
    rxLevel = 45; step(); chk("R6", "rtsN held", rtsN, 1);
    rxLevel = 30; manualRts = 0; step(); chk("R6", "rtsN manual off", rtsN, 1);
    manualRts = 1; step(); chk("R6", "rtsN hold cleared", rtsN, 0);

    // R2 general-purpose output when disabled
    autoRxEn = 0; rxLevel = 60; step(); chk("R2", "rtsN gpo on", rtsN, 0);
    manualRts = 0; step(); chk("R2", "rtsN gpo off", rtsN, 1);

    // R7 DTR selection
    autoRxEn = 1; lineSel = 1; manualDtr = 1; manualRts = 1; step();
    chk("R7", "dtrN held", dtrN, 1); chk("R7", "rtsN unselected", rtsN, 0);
    rxLevel = 10; step(); chk("R7", "dtrN released", dtrN, 0);

    // R9 transmit gating at boundaries, through the synchroniser
    lineSel = 0; autoTxEn = 1; txBoundary = 0; ctsN = 1;
    repeat (4) step(); chk("R9", "txAllow mid-char", txAllow, 1);
    txBoundary = 1; step(); chk("R9", "txAllow halted", txAllow, 0);
    ctsN = 0; step(); chk("R9", "txAllow sync delay", txAllow, 0);
    step(); chk("R9", "txAllow sync delay 2", txAllow, 0);
    step(); chk("R9", "txAllow resumed", txAllow, 1);
    ctsN = 1; dsrN = 0; lineSel = 1; repeat (3) step();
    chk("R9", "txAllow follows dsr", txAllow, 1);
    lineSel = 0; step(); chk("R9", "txAllow cts select", txAllow, 0);

    // R8 disable frees the transmitter
    autoTxEn = 0; step(); chk("R8", "txAllow free", txAllow, 1);

    // R10 interrupt threshold
    trigLevel = 10; rxLevel = 10; step(); chk("R10", "rxIrq at trig", rxIrq, 1);
    rxLevel = 9; step(); chk("R10", "rxIrq below trig", rxIrq, 0);

    // constrained random walk
    for (int i = 0; i < 4000; i++) begin
      int d;
      d = int'($urandom_range(6)) - 3;
      if (int'(rxLevel) + d < 0) rxLevel = 0;
      else if (int'(rxLevel) + d > 64) rxLevel = 64;
      else rxLevel = 7'(int'(rxLevel) + d);
      if ($urandom_range(99) < 2) upperThr = 7'($urandom_range(64));
      if ($urandom_range(99) < 2) lowerThr = 7'($urandom_range(64));
      if ($urandom_range(99) < 2) trigLevel = 7'($urandom_range(64));
      if ($urandom_range(99) < 3) autoRxEn = ~autoRxEn;
      if ($urandom_range(99) < 3) autoTxEn = ~autoTxEn;
      if ($urandom_range(99) < 2) lineSel = ~lineSel;
      if ($urandom_range(99) < 4) manualRts = ~manualRts;
      if ($urandom_range(99) < 4) manualDtr = ~manualDtr;
      if ($urandom_range(99) < 10) ctsN = ~ctsN;
      if ($urandom_range(99) < 10) dsrN = ~dsrN;
      txBoundary = $urandom_range(99) < 30;
      step();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule